// File: doc/BRIEF.md
# Multi-Device Gain Synchronization Bus

This block lets up to eight amplifier instances that share one open-drain wire agree on a common gain reduction. The wire is split into time slots that follow the audio bit clock and frame clock. A device whose local gain controller is reducing gain places its current gain code in the slot or slots it owns. It then releases the wire. It also listens to any chosen set of the other slots. At each frame boundary the block applies the lowest gain it has seen: the gain it measured itself or any gain it received. Because all devices collect the same frame and apply at the same boundary, they settle on the same value with one sample of latency.

One code, all ones, is reserved as an order to enter standby. A device sends it after its own gain controller has stayed at full attenuation too long. That device raises an interrupt pulse. Devices that only receive the order go to standby silently. A clock fault freezes the block so that the wire driver holds its last state.

The bit clock arrives as a one-cycle strobe `bit_tick` in the system clock domain. A frame begins on the strobe that has `frame_start` high. The result `gain_applied` comes with a one-cycle `gain_upd` valid strobe. It has no ready: the value stays in place until the next frame boundary, so there is no back-pressure to manage. A slot must be at least six bit periods wide, so `SLOT_BITS` must exceed the 5-bit gain width.

Top module: `gain_sync_bus`

## Requirements
- R1: A `bit_tick` with `frame_start` high starts bit 0 of slot 0. Each later accepted tick advances one bit. Slots are `SLOT_BITS` (default 8) ticks wide, and there are `N_SLOTS` (default 8) slots per frame.
- R2: While transmitting, the block drives every slot set in `cfg_tx_slots` as follows:
  - bit 0 is a start bit driven low;
  - bits 1 to 5 carry the 5-bit code, most significant bit first;
  - from bit 6 to the end of the slot `bus_oe` is low.
  The outputs for bit n are registered on the tick that starts bit n.
- R3: The transmit decision and the code are taken at the frame-start tick and hold for the whole frame. The block transmits when `cfg_bus_en` is high and either a local standby is pending or both `cfg_agc_en` and `agc_active` are high. In every other case `bus_oe` stays low.
- R4: Setting several bits in `cfg_tx_slots` repeats the same code in each of those slots within one frame.
- R5: A slot contributes a received gain only when all of the following hold:
  - its bit is set in `cfg_listen`;
  - `cfg_bus_en` is high;
  - the wire read low in its start bit.
  An idle slot reads high, because of the pull-up, and is ignored. The received code is the five bits that follow, most significant bit first.
- R6: On each frame-start tick after the first, `gain_applied` takes a new value and `gain_upd` pulses for one cycle. The new value is the minimum of all gains received in the frame just ended and the local term. The local term is `local_gain` when `cfg_agc_en` and `agc_active` are both high, and otherwise full gain, code 30.
- R7: With `cfg_agc_en` low, received gains are still applied, and the block does not transmit.
- R8: When `agc_timeout` first goes high, `standby` and `standby_irq` rise one cycle later. `standby_irq` lasts exactly one cycle. From the next frame on, code 31 (all ones) is transmitted in the owned slots.
- R9: Receiving code 31 in a listened slot sets `standby` without any `standby_irq`, and that code does not enter the minimum. Standby is left only through reset.
- R10: While `clk_err` is high, ticks are ignored. `bus_oe`, `bus_out`, `gain_applied` and the slot position all hold, and no update is produced.
- R11: After reset: `bus_oe` is low, `gain_applied` is 30, and `standby` and `standby_irq` are low.
- R12: With `cfg_bus_en` low, nothing is driven or received, and `gain_applied` follows the local term alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bit-clock period |
| frame_start | input | 1 | Marks the tick that opens a frame |
| clk_err | input | 1 | Clock fault, freezes the block |
| cfg_bus_en | input | 1 | Enables the bus interface |
| cfg_agc_en | input | 1 | Enables use of the local gain controller |
| cfg_tx_slots | input | N_SLOTS | Slots this device transmits in |
| cfg_listen | input | N_SLOTS | Slots this device listens to |
| agc_active | input | 1 | Local gain reduction in progress |
| local_gain | input | 5 | Locally measured gain code (0 to 30) |
| agc_timeout | input | 1 | Local controller stayed at full attenuation too long |
| bus_in | input | 1 | Level read from the shared wire |
| bus_out | output | 1 | Level to drive onto the wire |
| bus_oe | output | 1 | Output enable for the wire driver |
| gain_applied | output | 5 | Gain code in force |
| gain_upd | output | 1 | Valid strobe for a new `gain_applied` |
| standby | output | 1 | Standby request, local or received |
| standby_irq | output | 1 | One-cycle interrupt for a local standby |

## Verification
The wire outputs for bit n change on the very tick that opens bit n. The bench reads them one half clock later and compares them with the slot map. A received bit is sampled on the tick that closes it. For that reason the bench's remote driver changes the wire just after each tick, and the frame's minimum appears on the next frame-start tick. The driver pushes that expected value when the frame ends, and the monitor pops it on the `gain_upd` strobe. The standby interrupt is due one clock after `agc_timeout` rises, and the bench reads it on the following falling edges. Clock-fault windows are checked on every frozen tick.

// File: rtl/gsb_pkg.sv
package gsb_pkg;
  localparam int GAIN_W = 5;
  typedef logic [GAIN_W-1:0] gain_t;
  localparam gain_t GAIN_FULL    = gain_t'(30);
  localparam gain_t CODE_STANDBY = '1;

  function automatic gain_t gain_min(input gain_t a, input gain_t b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/gsb_slot_timer.sv
module gsb_slot_timer #(
  parameter int N_SLOTS   = 8,
  parameter int SLOT_BITS = 8,
  parameter int SL_W      = $clog2(N_SLOTS),
  parameter int BP_W      = $clog2(SLOT_BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_tick,
  input  logic            frame_start,
  input  logic            clk_err,
  output logic            tick_eff,
  output logic            frame_tick,
  output logic            synced,
  output logic [SL_W-1:0] cur_slot,
  output logic [BP_W-1:0] cur_bp,
  output logic [SL_W-1:0] nxt_slot,
  output logic [BP_W-1:0] nxt_bp
);
  localparam logic [BP_W-1:0] BP_LAST = BP_W'(SLOT_BITS - 1);
  localparam logic [SL_W-1:0] SL_LAST = SL_W'(N_SLOTS - 1);

  assign tick_eff   = bit_tick & ~clk_err;
  assign frame_tick = tick_eff & frame_start;

  always_comb begin
    nxt_slot = cur_slot;
    nxt_bp   = cur_bp + 1'b1;
    if (frame_start) begin
      nxt_slot = '0;
      nxt_bp   = '0;
    end else if (cur_bp == BP_LAST) begin
      nxt_bp   = '0;
      nxt_slot = (cur_slot == SL_LAST) ? '0 : cur_slot + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      synced   <= 1'b0;
      cur_slot <= '0;
      cur_bp   <= '0;
    end else if (tick_eff) begin
      if (frame_start) synced <= 1'b1;
      if (frame_start || synced) begin
        cur_slot <= nxt_slot;
        cur_bp   <= nxt_bp;
      end
    end
  end

  // R1
  frame_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> (cur_slot == '0 && cur_bp == '0 && synced));
endmodule

// File: rtl/gsb_tx.sv
module gsb_tx
  import gsb_pkg::*;
#(
  parameter int N_SLOTS   = 8,
  parameter int SLOT_BITS = 8,
  parameter int SL_W      = $clog2(N_SLOTS),
  parameter int BP_W      = $clog2(SLOT_BITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_eff,
  input  logic               frame_tick,
  input  logic [SL_W-1:0]    nxt_slot,
  input  logic [BP_W-1:0]    nxt_bp,
  input  logic [BP_W-1:0]    cur_bp,
  input  logic               cfg_bus_en,
  input  logic [N_SLOTS-1:0] cfg_tx_mask,
  input  logic               go_new,
  input  gain_t              code_new,
  output logic               bus_out,
  output logic               bus_oe
);
  localparam logic [BP_W-1:0] LAST_CODE_BP = BP_W'(GAIN_W);

  logic  go_r, go_now, drive_nxt, bit_nxt;
  gain_t code_r, code_now;

  always_comb begin
    int idx;
    go_now    = frame_tick ? go_new : go_r;
    code_now  = frame_tick ? code_new : code_r;
    drive_nxt = go_now && cfg_bus_en && cfg_tx_mask[nxt_slot] && (nxt_bp <= LAST_CODE_BP);
    idx       = GAIN_W - int'(nxt_bp);
    bit_nxt   = 1'b0;
    if (nxt_bp != '0 && idx >= 0 && idx < GAIN_W) bit_nxt = code_now[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_r    <= 1'b0;
      code_r  <= '0;
      bus_oe  <= 1'b0;
      bus_out <= 1'b0;
    end else if (tick_eff) begin
      go_r    <= go_now;
      code_r  <= code_now;
      bus_oe  <= drive_nxt;
      bus_out <= drive_nxt & bit_nxt;
    end
  end

  // R2
  start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && cur_bp == '0) |-> !bus_out);
  // R2
  release_after_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (cur_bp <= LAST_CODE_BP));
endmodule

// File: rtl/gsb_rx.sv
module gsb_rx
  import gsb_pkg::*;
#(
  parameter int N_SLOTS   = 8,
  parameter int SLOT_BITS = 8,
  parameter int SL_W      = $clog2(N_SLOTS),
  parameter int BP_W      = $clog2(SLOT_BITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_eff,
  input  logic               frame_tick,
  input  logic               synced,
  input  logic [SL_W-1:0]    cur_slot,
  input  logic [BP_W-1:0]    cur_bp,
  input  logic               bus_in,
  input  logic               cfg_bus_en,
  input  logic [N_SLOTS-1:0] cfg_listen,
  input  gain_t              local_term,
  output gain_t              gain_applied,
  output logic               gain_upd,
  output logic               rx_standby
);
  localparam logic [BP_W-1:0] LAST_CODE_BP = BP_W'(GAIN_W);

  logic  start_ok;
  gain_t shreg, acc, rx_code;
  logic  slot_done;

  assign rx_code   = {shreg[GAIN_W-2:0], bus_in};
  assign slot_done = tick_eff && synced && (cur_bp == LAST_CODE_BP) && start_ok
                     && cfg_listen[cur_slot] && cfg_bus_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_ok     <= 1'b0;
      shreg        <= '0;
      acc          <= GAIN_FULL;
      gain_applied <= GAIN_FULL;
      gain_upd     <= 1'b0;
      rx_standby   <= 1'b0;
    end else begin
      gain_upd <= 1'b0;
      if (tick_eff && synced) begin
        if (cur_bp == '0) begin
          start_ok <= ~bus_in;
          shreg    <= '0;
        end else if (cur_bp <= LAST_CODE_BP) begin
          shreg <= rx_code;
        end
      end
      if (slot_done) begin
        if (rx_code == CODE_STANDBY) rx_standby <= 1'b1;
        else                         acc <= gain_min(acc, rx_code);
      end
      if (frame_tick && synced) begin
        gain_applied <= gain_min(acc, local_term);
        gain_upd     <= 1'b1;
        acc          <= GAIN_FULL;
      end
    end
  end

  // R6
  applied_not_above_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gain_upd |-> (gain_applied <= $past(local_term)));
endmodule

// File: rtl/gain_sync_bus.sv
module gain_sync_bus
  import gsb_pkg::*;
#(
  parameter int N_SLOTS   = 8,
  parameter int SLOT_BITS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_tick,
  input  logic               frame_start,
  input  logic               clk_err,
  input  logic               cfg_bus_en,
  input  logic               cfg_agc_en,
  input  logic [N_SLOTS-1:0] cfg_tx_slots,
  input  logic [N_SLOTS-1:0] cfg_listen,
  input  logic               agc_active,
  input  logic [GAIN_W-1:0]  local_gain,
  input  logic               agc_timeout,
  input  logic               bus_in,
  output logic               bus_out,
  output logic               bus_oe,
  output logic [GAIN_W-1:0]  gain_applied,
  output logic               gain_upd,
  output logic               standby,
  output logic               standby_irq
);
  localparam int SL_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
  localparam int BP_W = $clog2(SLOT_BITS);

  logic            tick_eff, frame_tick, synced;
  logic [SL_W-1:0] cur_slot, nxt_slot;
  logic [BP_W-1:0] cur_bp, nxt_bp;
  logic            local_stby, rx_stby, local_used, go_new;
  gain_t           local_term, code_new;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      local_stby  <= 1'b0;
      standby_irq <= 1'b0;
    end else begin
      local_stby  <= local_stby | agc_timeout;
      standby_irq <= agc_timeout & ~local_stby;
    end
  end

  assign standby    = local_stby | rx_stby;
  assign local_used = cfg_agc_en & agc_active;
  assign local_term = local_used ? gain_min(local_gain, GAIN_FULL) : GAIN_FULL;
  assign go_new     = cfg_bus_en & (local_stby | local_used);
  assign code_new   = local_stby ? CODE_STANDBY : local_gain;

  gsb_slot_timer #(.N_SLOTS(N_SLOTS), .SLOT_BITS(SLOT_BITS), .SL_W(SL_W), .BP_W(BP_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_start(frame_start),
    .clk_err(clk_err), .tick_eff(tick_eff), .frame_tick(frame_tick), .synced(synced),
    .cur_slot(cur_slot), .cur_bp(cur_bp), .nxt_slot(nxt_slot), .nxt_bp(nxt_bp)
  );

  gsb_tx #(.N_SLOTS(N_SLOTS), .SLOT_BITS(SLOT_BITS), .SL_W(SL_W), .BP_W(BP_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick_eff(tick_eff), .frame_tick(frame_tick),
    .nxt_slot(nxt_slot), .nxt_bp(nxt_bp), .cur_bp(cur_bp), .cfg_bus_en(cfg_bus_en),
    .cfg_tx_mask(cfg_tx_slots), .go_new(go_new), .code_new(code_new),
    .bus_out(bus_out), .bus_oe(bus_oe)
  );

  gsb_rx #(.N_SLOTS(N_SLOTS), .SLOT_BITS(SLOT_BITS), .SL_W(SL_W), .BP_W(BP_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick_eff(tick_eff), .frame_tick(frame_tick),
    .synced(synced), .cur_slot(cur_slot), .cur_bp(cur_bp), .bus_in(bus_in),
    .cfg_bus_en(cfg_bus_en), .cfg_listen(cfg_listen), .local_term(local_term),
    .gain_applied(gain_applied), .gain_upd(gain_upd), .rx_standby(rx_stby)
  );

  // R10
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_err |=> ($stable(bus_oe) && $stable(bus_out) && $stable(gain_applied) && !gain_upd));
  // R8
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby_irq |=> !standby_irq);
  // R9
  irq_only_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby_irq |-> ($past(agc_timeout) && standby));
  // R6
  update_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gain_upd |-> $past(frame_start && bit_tick && !clk_err));
endmodule

// File: tb/tb_gain_sync_bus.sv
module tb_gain_sync_bus;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, frame_start = 1'b0, clk_err = 1'b0;
  logic cfg_bus_en = 1'b0, cfg_agc_en = 1'b0;
  logic [7:0] cfg_tx_slots = '0, cfg_listen = '0;
  logic agc_active = 1'b0, agc_timeout = 1'b0;
  logic [4:0] local_gain = '0;
  logic bus_out, bus_oe, gain_upd, standby, standby_irq;
  logic [4:0] gain_applied;
  logic r_oe = 1'b0, r_v = 1'b1;
  logic bus_line;

  int total = 0, bad = 0, irq_cnt = 0;
  logic [4:0] expq[$];
  logic [4:0] popped;
  logic exp_tx = 1'b0;
  logic [4:0] exp_code = '0;
  bit finished = 0;

  assign bus_line = (bus_oe ? bus_out : 1'b1) & (r_oe ? r_v : 1'b1);

  gain_sync_bus dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_start(frame_start),
    .clk_err(clk_err), .cfg_bus_en(cfg_bus_en), .cfg_agc_en(cfg_agc_en),
    .cfg_tx_slots(cfg_tx_slots), .cfg_listen(cfg_listen), .agc_active(agc_active),
    .local_gain(local_gain), .agc_timeout(agc_timeout), .bus_in(bus_line),
    .bus_out(bus_out), .bus_oe(bus_oe), .gain_applied(gain_applied),
    .gain_upd(gain_upd), .standby(standby), .standby_irq(standby_irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor (R6)
  always @(negedge clk) begin
    if (rst_n && standby_irq) irq_cnt++;
    if (rst_n && gain_upd) begin
      if (expq.size() == 0) chk(1'b0, "R6", "unexpected gain update", gain_applied, 0);
      else begin
        popped = expq.pop_front();
        chk(gain_applied == popped, "R6", "applied gain", gain_applied, popped);
      end
    end
  end

  function automatic logic [4:0] exp_gain(input logic [7:0][4:0] rg, input logic [7:0] pres);
    logic [4:0] m;
    m = (cfg_agc_en && agc_active) ? local_gain : 5'd30;
    if (cfg_bus_en)
      for (int s = 0; s < 8; s++)
        if (cfg_listen[s] && pres[s] && rg[s] != 5'd31 && rg[s] < m) m = rg[s];
    return m;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_tick = 0; frame_start = 0; clk_err = 0; agc_timeout = 0;
    r_oe = 0; r_v = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expq.delete();
    irq_cnt = 0;
    @(negedge clk);
  endtask

  task automatic run_frame(input logic [7:0][4:0] rg, input logic [7:0] pres,
                           input int frz, input string req);
    int txerr, frzerr, sl, bp;
    logic ho, hd;
    logic [4:0] ge;
    txerr = 0; frzerr = 0;
    ge = exp_gain(rg, pres);
    for (int b = 0; b < 64; b++) begin
      sl = b / 8; bp = b % 8;
      if (b == frz) begin
        @(negedge clk); clk_err = 1'b1; ho = bus_oe; hd = bus_out;
        for (int k = 0; k < 5; k++) begin
          @(negedge clk) bit_tick = 1'b1;
          @(negedge clk) bit_tick = 1'b0;
          if (bus_oe !== ho || bus_out !== hd) frzerr++;
        end
        chk(frzerr == 0, "R10", "driver held during clock fault", frzerr, 0);
        @(negedge clk); clk_err = 1'b0;
      end
      @(negedge clk); bit_tick = 1'b1; frame_start = (b == 0);
      @(negedge clk); bit_tick = 1'b0; frame_start = 1'b0;
      r_oe = pres[sl] && bp <= 5;
      r_v  = (bp == 0) ? 1'b0 : ((bp <= 5) ? rg[sl][5-bp] : 1'b1);
      if (bus_oe !== (exp_tx && cfg_tx_slots[sl] && bp <= 5)) txerr++;
      else if (bus_oe && bus_out !== ((bp == 0) ? 1'b0 : exp_code[5-bp])) txerr++;
      @(negedge clk);
    end
    r_oe = 1'b0;
    chk(txerr == 0, req, "slot drive pattern", txerr, 0);
    expq.push_back(ge);
  endtask

  task automatic flush();
    @(negedge clk); bit_tick = 1'b1; frame_start = 1'b1;
    @(negedge clk); bit_tick = 1'b0; frame_start = 1'b0;
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R6", "all frame results delivered", expq.size(), 0);
  endtask

  initial begin
    logic [7:0][4:0] rg;
    do_reset();
    // R11 reset state
    chk(bus_oe == 1'b0, "R11", "bus_oe after reset", bus_oe, 0);
    chk(gain_applied == 5'd30, "R11", "gain after reset", gain_applied, 30);
    chk(standby == 1'b0, "R11", "standby after reset", standby, 0);
    chk(standby_irq == 1'b0, "R11", "irq after reset", standby_irq, 0);

    // R2 R5 R6: local active, two remotes
    cfg_bus_en = 1; cfg_agc_en = 1; agc_active = 1; local_gain = 5'd20;
    cfg_tx_slots = 8'h04; cfg_listen = 8'h22;
    exp_tx = 1; exp_code = 5'd20;
    rg = '0; rg[1] = 5'd25; rg[5] = 5'd12;
    run_frame(rg, 8'h22, -1, "R2");
    run_frame(rg, 8'h02, -1, "R2");
    flush();

    // R3 R5: local inactive, unlistened slot ignored
    do_reset();
    agc_active = 0; exp_tx = 0;
    rg = '0; rg[1] = 5'd18; rg[6] = 5'd3;
    run_frame(rg, 8'h42, -1, "R3");
    flush();

    // R7: local controller disabled, bus still followed
    do_reset();
    cfg_agc_en = 0; agc_active = 1; local_gain = 5'd5; exp_tx = 0;
    rg = '0; rg[1] = 5'd22;
    run_frame(rg, 8'h02, -1, "R7");
    flush();

    // R5: idle listened slots read high and are ignored
    do_reset();
    cfg_agc_en = 1; agc_active = 0; cfg_listen = 8'hFF; exp_tx = 0;
    rg = '0;
    run_frame(rg, 8'h00, -1, "R5");
    flush();

    // R4: repeated code in two slots
    do_reset();
    agc_active = 1; local_gain = 5'd9; cfg_tx_slots = 8'h11; cfg_listen = 8'h00;
    exp_tx = 1; exp_code = 5'd9;
    run_frame(rg, 8'h00, -1, "R4");
    flush();

    // R12: bus disabled
    do_reset();
    cfg_bus_en = 0; local_gain = 5'd17; cfg_listen = 8'h02; exp_tx = 0;
    rg = '0; rg[1] = 5'd4;
    run_frame(rg, 8'h02, -1, "R12");
    flush();

    // R10: clock fault mid transmission
    do_reset();
    cfg_bus_en = 1; cfg_tx_slots = 8'h04; local_gain = 5'd11; cfg_listen = 8'h02;
    exp_tx = 1; exp_code = 5'd11;
    rg = '0; rg[1] = 5'd13;
    run_frame(rg, 8'h02, 19, "R10");
    flush();

    // R9: received standby order
    do_reset();
    agc_active = 0; cfg_tx_slots = 8'h00; cfg_listen = 8'h0A; exp_tx = 0;
    rg = '0; rg[1] = 5'd14; rg[3] = 5'd31;
    run_frame(rg, 8'h0A, -1, "R9");
    flush();
    chk(standby == 1'b1, "R9", "standby from bus order", standby, 1);
    chk(irq_cnt == 0, "R9", "no irq for received order", irq_cnt, 0);

    // R8: local timeout
    do_reset();
    agc_active = 1; local_gain = 5'd8; cfg_tx_slots = 8'h40; cfg_listen = 8'h00;
    @(negedge clk); agc_timeout = 1'b1;
    @(negedge clk);
    chk(standby_irq == 1'b1, "R8", "irq one cycle after timeout", standby_irq, 1);
    chk(standby == 1'b1, "R8", "standby after timeout", standby, 1);
    @(negedge clk);
    chk(standby_irq == 1'b0, "R8", "irq is one cycle", standby_irq, 0);
    exp_tx = 1; exp_code = 5'd31;
    rg = '0;
    run_frame(rg, 8'h00, -1, "R8");
    flush();
    chk(irq_cnt == 1, "R8", "irq count", irq_cnt, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule